// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block keeps a 16-bit register of interrupt flags and a 16-bit register of enables for a small processor system. Each peripheral raises a one-cycle request pulse on its own line, and the pulse sets the matching flag. A flag stays set until software clears it. A single level output, `irq_pending`, tells the CPU that at least one flag is set and also enabled.

Software reaches both registers over a simple register bus. The read data is combinational and depends only on the address. A write takes effect at the clock edge where `bus_en` and `bus_we` are both high.

A write to the flag register acknowledges events by AND-ing the written value into the flags. A zero bit clears that flag and a one bit leaves it as it is. This is the reverse of the common write-one-to-clear scheme. A write to the enable register replaces its whole contents. Request line 3 also has a dedicated input, `dma_req`, for the DMA controller.

Top module: `irq_status_mask`

## Requirements
- R1: While `rst_n` is low at a clock edge, both registers become 0 and `irq_pending` is low from the following cycle on.
- R2: A pulse on `src_pulse[i]` at a clock edge sets flag bit i. Without software action, a set flag stays set through later cycles that carry no pulse.
- R3: A write to address 0x1070 makes the flags equal to the old flags AND `bus_wdata[15:0]`. A 0 bit clears that flag and a 1 bit keeps it.
- R4: A write to address 0x1074 replaces the enable register with `bus_wdata[15:0]`. The enable register keeps its value when it is not written.
- R5: If a source pulse and a flag write arrive at the same clock edge, every pulsed bit is set after that edge, even if the written data has a 0 there.
- R6: In every cycle, `irq_pending` is 1 exactly when (flags AND enables) is nonzero for the current register contents.
- R7: Writing an enable bit for a flag that is already set raises `irq_pending` in the next cycle, with no new pulse needed.
- R8: A pulse on `dma_req` sets flag bit 3, just as `src_pulse[3]` does.
- R9: `bus_rdata` shows the flags at address 0x1070 and the enables at 0x1074, zero-extended to 32 bits. Any other address reads 0.
- R10: `bus_wdata[31:16]` has no effect. Writes to any address other than 0x1070 or 0x1074 change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_pulse | input | 16 | One-cycle request pulses, one line per flag bit |
| dma_req | input | 1 | DMA controller request pulse, merged into flag bit 3 |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 16 | Register offset |
| bus_wdata | input | 32 | Write data; only the low 16 bits are used |
| bus_rdata | output | 32 | Read data for `bus_addr`, zero-extended |
| irq_pending | output | 1 | High when any flag is both set and enabled |

## Verification
The bench first targets the acknowledge rule. It writes patterns that mix 0 and 1 bits and checks that only the zero positions are cleared. A design using write-one-to-clear would instead clear exactly the bits that should survive.

It then lands a source pulse on the same edge as an all-zero flag write. A design that gives the write priority would lose that event.

It also sets a flag while its enable is off and enables it later, checking that the pending line follows at once. A design that detects new edges instead of levels would never assert there.

Finally, it writes values with nonzero upper halves and writes to neighbouring offsets. A decoder that is too wide would then corrupt a register.

// File: rtl/irq_ctl_pkg.sv
// Package: irq_ctl_pkg
// Holds the constants and the small types shared by the interrupt status
// and mask controller. Assumes a 16-bit register offset space and a
// 32-bit data bus.
package irq_ctl_pkg;

    localparam int unsigned IRQ_W      = 16;
    localparam int unsigned ADDR_W     = 16;
    localparam int unsigned DATA_W     = 32;
    localparam int unsigned DMA_BIT    = 3;
    localparam logic [ADDR_W-1:0] FLAG_OFS = 16'h1070;
    localparam logic [ADDR_W-1:0] ENAB_OFS = 16'h1074;

    // Which register, if any, the current bus address selects.
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_FLAG = 2'd1,
        SEL_ENAB = 2'd2
    } reg_sel_e;

endpackage

// File: rtl/irq_bus_decode.sv
// Module: irq_bus_decode
// Decodes the register bus into one-hot write strobes, picks the register
// to read, and trims the write data to the register width.
// Assumes: exact match on the offsets; the write data above the register
// width is dropped.
module irq_bus_decode
    import irq_ctl_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned DW = DATA_W,
    parameter int unsigned RW = IRQ_W,
    parameter logic [AW-1:0] FLAG_ADDR = FLAG_OFS,
    parameter logic [AW-1:0] ENAB_ADDR = ENAB_OFS
) (
    input  logic          en_i,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output reg_sel_e      sel_o,
    output logic          flag_wr_o,
    output logic          enab_wr_o,
    output logic [RW-1:0] wval_o
);

    logic [DW-RW-1:0] wdata_unused;

    // Map the address onto a register selector.
    always_comb begin
        if (addr_i == FLAG_ADDR)      sel_o = SEL_FLAG;
        else if (addr_i == ENAB_ADDR) sel_o = SEL_ENAB;
        else                          sel_o = SEL_NONE;
    end

    // Produce the write strobes for a qualified write cycle.
    always_comb begin
        flag_wr_o = en_i && we_i && (sel_o == SEL_FLAG);
        enab_wr_o = en_i && we_i && (sel_o == SEL_ENAB);
    end

    // Keep only the low half of the write data.
    assign wval_o       = wdata_i[RW-1:0];
    assign wdata_unused = wdata_i[DW-1:RW];

endmodule

// File: rtl/irq_flag_reg.sv
// Module: irq_flag_reg
// Holds the interrupt flags. A set pulse latches a bit. A software write
// ANDs the written value into the flags. When both happen on one edge,
// the set wins.
// Assumes: set pulses last one cycle and are already merged per bit.
module irq_flag_reg #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         wr_i,
    input  logic [W-1:0] wval_i,
    output logic [W-1:0] flag_o
);

    logic past_ok;

    // Arm the assertions once one non-reset cycle has passed.
    always_ff @(posedge clk) begin
        past_ok <= rst_n;
    end

    for (genvar b = 0; b < W; b++) begin : g_bit
        // Per-bit update: clear on reset, set on pulse, otherwise AND on write.
        always_ff @(posedge clk) begin
            if (!rst_n)              flag_o[b] <= 1'b0;
            else if (set_i[b])       flag_o[b] <= 1'b1;
            else if (wr_i)           flag_o[b] <= flag_o[b] & wval_i[b];
        end
    end

    AST_ACK_AND: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        wr_i |=> ((flag_o & ~$past(set_i)) == ($past(flag_o) & $past(wval_i) & ~$past(set_i)))); // R3

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (set_i != '0) |=> ((flag_o & $past(set_i)) == $past(set_i))); // R5

    AST_NO_SPONT_SET: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        1'b1 |=> ((flag_o & ~$past(flag_o) & ~$past(set_i)) == '0)); // R2

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (!wr_i && set_i == '0) |=> $stable(flag_o)); // R2

endmodule

// File: rtl/irq_enab_reg.sv
// Module: irq_enab_reg
// Holds the interrupt enable mask. A write replaces the whole mask.
// Assumes: the write strobe is qualified already.
module irq_enab_reg #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wval_i,
    output logic [W-1:0] enab_o
);

    logic past_ok;

    // Arm the assertions once one non-reset cycle has passed.
    always_ff @(posedge clk) begin
        past_ok <= rst_n;
    end

    // Load the mask on a write, clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    enab_o <= '0;
        else if (wr_i) enab_o <= wval_i;
    end

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        wr_i |=> (enab_o == $past(wval_i))); // R4

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        !wr_i |=> $stable(enab_o)); // R4

endmodule

// File: rtl/irq_status_mask.sv
// Module: irq_status_mask (top)
// Interrupt flag and enable register pair with a level pending output.
// Source pulses, including the DMA request merged into its own bit, set
// flags. Software acknowledges flags with an AND-write and sets the mask
// with a full write. irq_pending is the OR of flags AND enables.
// Assumes: single-cycle source pulses; synchronous active-low reset.
module irq_status_mask
    import irq_ctl_pkg::*;
#(
    parameter int unsigned NSRC  = IRQ_W,
    parameter int unsigned AW    = ADDR_W,
    parameter int unsigned DW    = DATA_W,
    parameter int unsigned DMA_B = DMA_BIT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NSRC-1:0] src_pulse,
    input  logic          dma_req,
    input  logic          bus_en,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq_pending
);

    localparam int unsigned PAD_W = DW - NSRC;

    reg_sel_e        sel;
    logic            flag_wr;
    logic            enab_wr;
    logic [NSRC-1:0] wval;
    logic [NSRC-1:0] set_vec;
    logic [NSRC-1:0] flags;
    logic [NSRC-1:0] enables;
    logic            past_ok;

    // Arm the top-level assertions once one non-reset cycle has passed.
    always_ff @(posedge clk) begin
        past_ok <= rst_n;
    end

    irq_bus_decode #(
        .AW(AW), .DW(DW), .RW(NSRC)
    ) u_dec (
        .en_i      (bus_en),
        .we_i      (bus_we),
        .addr_i    (bus_addr),
        .wdata_i   (bus_wdata),
        .sel_o     (sel),
        .flag_wr_o (flag_wr),
        .enab_wr_o (enab_wr),
        .wval_o    (wval)
    );

    // Merge the DMA request into its flag bit.
    always_comb begin
        set_vec        = src_pulse;
        set_vec[DMA_B] = src_pulse[DMA_B] | dma_req;
    end

    irq_flag_reg #(.W(NSRC)) u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_vec),
        .wr_i   (flag_wr),
        .wval_i (wval),
        .flag_o (flags)
    );

    irq_enab_reg #(.W(NSRC)) u_enab (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (enab_wr),
        .wval_i (wval),
        .enab_o (enables)
    );

    // Read mux, zero-extended to the bus width.
    always_comb begin
        unique case (sel)
            SEL_FLAG: bus_rdata = {{PAD_W{1'b0}}, flags};
            SEL_ENAB: bus_rdata = {{PAD_W{1'b0}}, enables};
            default:  bus_rdata = '0;
        endcase
    end

    // Pending level from the current register contents.
    assign irq_pending = |(flags & enables);

    AST_DMA_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        dma_req |=> flags[DMA_B]); // R8

    AST_UNMASK_RAISES: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (enab_wr && ((flags & wval) != '0)) |=> irq_pending); // R7

    AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DW-1:NSRC] == '0); // R9

endmodule

// File: tb/test_irq_status_mask.sv
// Directed bench for irq_status_mask. Each scenario task drives its own
// stimulus and checks the results against a reference model kept in the bench.
module test_irq_status_mask;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] src_pulse = '0;
    logic        dma_req = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_pending;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    localparam logic [15:0] A_FLAG = 16'h1070;
    localparam logic [15:0] A_ENAB = 16'h1074;

    always #5 clk = ~clk;

    irq_status_mask i_irq_status_mask (
        .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .dma_req(dma_req),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_pending(irq_pending)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Combinational read at the falling edge.
    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_en = 1'b0;
    endtask

    // One write cycle, with optional pulses on the same edge.
    task automatic wr(input logic [15:0] a, input logic [31:0] d, input logic [15:0] p);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; src_pulse = p;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; bus_wdata = '0; src_pulse = '0;
    endtask

    task automatic pulse(input logic [15:0] p, input logic dma);
        @(negedge clk);
        src_pulse = p; dma_req = dma;
        @(negedge clk);
        src_pulse = '0; dma_req = 1'b0;
    endtask

    task automatic expect_regs(input string req, input logic [15:0] f, input logic [15:0] m);
        logic [31:0] d;
        rd(A_FLAG, d); check({req, " flags"}, d, {16'h0, f});
        rd(A_ENAB, d); check({req, " mask"}, d, {16'h0, m});
        check({req, " pending R6"}, {31'h0, irq_pending}, {31'h0, |(f & m)});
    endtask

    task automatic t_reset;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        expect_regs("R1", 16'h0, 16'h0);
    endtask

    task automatic t_latch;
        pulse(16'h0005, 1'b0);
        expect_regs("R2", 16'h0005, 16'h0);
        repeat (3) @(negedge clk);
        expect_regs("R2 hold", 16'h0005, 16'h0);
    endtask

    task automatic t_dma;
        pulse(16'h0000, 1'b1);
        expect_regs("R8", 16'h000D, 16'h0);
    endtask

    task automatic t_unmask;
        wr(A_ENAB, 32'h0000_0004, 16'h0);
        expect_regs("R7 R4", 16'h000D, 16'h0004);
        check("R7 pending", {31'h0, irq_pending}, 32'h1);
        wr(A_ENAB, 32'h0000_0002, 16'h0);
        expect_regs("R4 replace", 16'h000D, 16'h0002);
        check("R6 masked off", {31'h0, irq_pending}, 32'h0);
    endtask

    task automatic t_ack;
        wr(A_FLAG, 32'h0000_FFFB, 16'h0);
        expect_regs("R3 clear zero bit", 16'h0009, 16'h0002);
        wr(A_FLAG, 32'h0000_FFFF, 16'h0);
        expect_regs("R3 ones keep", 16'h0009, 16'h0002);
        wr(A_ENAB, 32'h0000_0008, 16'h0);
        check("R6 bit3 pending", {31'h0, irq_pending}, 32'h1);
        wr(A_FLAG, 32'h0000_0001, 16'h0);
        expect_regs("R3 ack bit3", 16'h0001, 16'h0008);
    endtask

    task automatic t_race;
        wr(A_FLAG, 32'h0000_0000, 16'h0100);
        expect_regs("R5 set wins", 16'h0100, 16'h0008);
    endtask

    task automatic t_upper_other;
        logic [31:0] d;
        wr(A_ENAB, 32'hABCD_0110, 16'h0);
        expect_regs("R10 upper ignored", 16'h0100, 16'h0110);
        check("R6 asserted", {31'h0, irq_pending}, 32'h1);
        wr(A_FLAG, 32'hFFFF_FEFF, 16'h0);
        expect_regs("R10 upper no keep", 16'h0000, 16'h0110);
        pulse(16'h0030, 1'b0);
        wr(16'h1078, 32'h0000_0000, 16'h0);
        wr(16'h1072, 32'h0000_0000, 16'h0);
        wr(16'h0070, 32'h0000_0000, 16'h0);
        expect_regs("R10 other offsets", 16'h0030, 16'h0110);
        rd(16'h1078, d); check("R9 other reads zero", d, 32'h0);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_latch();
        t_dma();
        t_unmask();
        t_ack();
        t_race();
        t_upper_other();
        t_reset();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule